// File: doc/BRIEF.md
# Pending Event Filter Unit

This block guards the short list of scheduled output changes for a single gate output inside a hardware event-driven logic simulator. It holds at most two pending changes, each a time stamp and a three-state value, ordered by time, alongside the value the output currently shows. Each cycle it may receive one proposed change. Depending on where the proposed time falls relative to the pending list, it drops the proposal as useless work, appends it, puts it at the head, or overwrites a pending change that the proposal has made obsolete. A narrow pulse that would reach the output and then revert within an inertial window is cancelled outright.

A retire strobe carrying the simulator's current time pops the earliest pending change once its time has arrived, and that value becomes the committed output. Values are 2-bit codes: 2'b00 is logic 0, 2'b11 is logic 1 and 2'b10 is unknown. Computing gate delays and ordering events across gates are left to the surrounding engine.

Top module: `pending_event_filter`

## Requirements
- R1: Reset sets the committed output to unknown (2'b10), the pending count to 0 and the overflow flag to 0.
- R2: With nothing pending, a proposal is stored as the single entry only if its value differs from the committed output, and is dropped otherwise.
- R3: A proposal whose time is later than the last pending entry is appended only if its value differs from that last entry's value, and is dropped otherwise.
- R4: A proposal whose time is not later than the head entry becomes the new head. The old head is removed if it carries the same value as the proposal, and otherwise it moves to second place.
- R5: With two entries pending, a proposal whose time is later than the head but not later than the second entry is dropped if its value equals the head value. Otherwise it takes the second slot, replacing the second entry.
- R6: When an appended proposal would return the output to the value in force before the last pending entry, and it is less than the inertial delay after that entry, the last entry is deleted and the proposal is dropped. This holds whether the earlier value is the committed output or the head entry's value.
- R7: When an accepted proposal would make three distinct pending entries, the two earliest in time are kept, and the overflow output is high for the one cycle after that proposal.
- R8: A retire strobe whose time equals the head entry's time pops the head at the next clock edge, and the popped value becomes the committed output. Any other retire leaves the committed output and the list unchanged.
- R9: When retire and a proposal arrive in the same cycle, the retire is applied first and the proposal is filtered against the list as it stands after the pop.
- R10: Whenever two entries are pending, the head time is not later than the second time, and the two values differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prop_valid | input | 1 | A proposed change is presented this cycle |
| prop_val | input | 2 | Proposed value code |
| prop_time | input | TW | Proposed change time |
| inertial_dly | input | TW | Minimum pulse width; 0 disables cancellation |
| retire | input | 1 | Retire strobe |
| cur_time | input | TW | Current simulation time for the retire strobe |
| out_val | output | 2 | Committed output value |
| pend_cnt | output | 2 | Number of pending entries (0 to 2) |
| head_time | output | TW | Time of the earliest entry (valid when pend_cnt is 1 or more) |
| head_val | output | 2 | Value of the earliest entry |
| tail_time | output | TW | Time of the second entry (valid when pend_cnt is 2) |
| tail_val | output | 2 | Value of the second entry |
| overflow | output | 1 | A third distinct entry was refused in the previous cycle |

## Verification
On every cycle the assertions check the list invariants of time order and distinct neighbours, the bound on the count, and the fact that the committed output moves only on a matching retire and then takes the popped value. They also check that an overflow always leaves a full list, and that proposals which are duplicates of the committed output or of the last entry are dropped. Which way each placement case resolves can only be shown by the bench's scenarios: head insertion with removal, middle replacement, inertial cancellation against both the committed value and the head value, and the ordering of retire and proposal in one cycle. The bench runs directed sequences through each of these and then a long random run compared against a requirement-level model.

// File: rtl/pef_pkg.sv
package pef_pkg;
    localparam int VW = 2;

    localparam logic [VW-1:0] V_ZERO = 2'b00;
    localparam logic [VW-1:0] V_ONE  = 2'b11;
    localparam logic [VW-1:0] V_UNK  = 2'b10;

    typedef enum logic [1:0] {
        K_EMPTY,
        K_APPEND,
        K_HEAD,
        K_MID
    } place_e;
endpackage

// File: rtl/pef_retire.sv
module pef_retire
    import pef_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          retire,
    input  logic [TW-1:0] cur_time,
    input  logic [1:0]    cnt_i,
    input  logic [VW-1:0] commit_i,
    input  logic [TW-1:0] t0_i,
    input  logic [VW-1:0] v0_i,
    input  logic [TW-1:0] t1_i,
    input  logic [VW-1:0] v1_i,
    output logic [1:0]    cnt_o,
    output logic [VW-1:0] commit_o,
    output logic [TW-1:0] t0_o,
    output logic [VW-1:0] v0_o,
    output logic [TW-1:0] t1_o,
    output logic [VW-1:0] v1_o
);
    logic pop;

    always_comb begin
        pop      = retire && (cnt_i != 2'd0) && (t0_i == cur_time);
        cnt_o    = cnt_i;
        commit_o = commit_i;
        t0_o     = t0_i;
        v0_o     = v0_i;
        t1_o     = t1_i;
        v1_o     = v1_i;
        if (pop) begin
            commit_o = v0_i;
            t0_o     = t1_i;
            v0_o     = v1_i;
            cnt_o    = cnt_i - 2'd1;
        end
    end
endmodule

// File: rtl/pef_classify.sv
module pef_classify
    import pef_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [1:0]    cnt_i,
    input  logic [TW-1:0] t0_i,
    input  logic [TW-1:0] t1_i,
    input  logic [TW-1:0] new_time,
    output place_e        place
);
    logic [TW-1:0] last_t;

    always_comb begin
        last_t = (cnt_i == 2'd2) ? t1_i : t0_i;
        if (cnt_i == 2'd0) begin
            place = K_EMPTY;
        end else if (new_time > last_t) begin
            place = K_APPEND;
        end else if (new_time <= t0_i) begin
            place = K_HEAD;
        end else begin
            place = K_MID;
        end
    end
endmodule

// File: rtl/pef_merge.sv
module pef_merge
    import pef_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          valid,
    input  place_e        place,
    input  logic [VW-1:0] new_val,
    input  logic [TW-1:0] new_time,
    input  logic [TW-1:0] inertial,
    input  logic [1:0]    cnt_i,
    input  logic [VW-1:0] commit_i,
    input  logic [TW-1:0] t0_i,
    input  logic [VW-1:0] v0_i,
    input  logic [TW-1:0] t1_i,
    input  logic [VW-1:0] v1_i,
    output logic [1:0]    cnt_o,
    output logic [TW-1:0] t0_o,
    output logic [VW-1:0] v0_o,
    output logic [TW-1:0] t1_o,
    output logic [VW-1:0] v1_o,
    output logic          ovf_o
);
    logic [TW-1:0] last_t;
    logic [VW-1:0] last_v;
    logic [VW-1:0] prior_v;
    logic [TW-1:0] gap;

    always_comb begin
        last_t  = (cnt_i == 2'd2) ? t1_i : t0_i;
        last_v  = (cnt_i == 2'd2) ? v1_i : v0_i;
        prior_v = (cnt_i == 2'd2) ? v0_i : commit_i;
        gap     = new_time - last_t;

        cnt_o = cnt_i;
        t0_o  = t0_i;
        v0_o  = v0_i;
        t1_o  = t1_i;
        v1_o  = v1_i;
        ovf_o = 1'b0;

        if (valid) begin
            unique case (place)
                K_EMPTY: begin
                    if (new_val != commit_i) begin
                        cnt_o = 2'd1;
                        t0_o  = new_time;
                        v0_o  = new_val;
                    end
                end
                K_APPEND: begin
                    if (new_val != last_v) begin
                        if ((new_val == prior_v) && (gap < inertial)) begin
                            cnt_o = cnt_i - 2'd1;
                        end else if (cnt_i == 2'd1) begin
                            cnt_o = 2'd2;
                            t1_o  = new_time;
                            v1_o  = new_val;
                        end else begin
                            ovf_o = 1'b1;
                        end
                    end
                end
                K_HEAD: begin
                    t0_o = new_time;
                    v0_o = new_val;
                    if (v0_i != new_val) begin
                        t1_o  = t0_i;
                        v1_o  = v0_i;
                        cnt_o = 2'd2;
                        ovf_o = (cnt_i == 2'd2);
                    end
                end
                K_MID: begin
                    if (new_val != v0_i) begin
                        t1_o  = new_time;
                        v1_o  = new_val;
                        ovf_o = (v1_i != new_val);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pending_event_filter.sv
module pending_event_filter
    import pef_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prop_valid,
    input  logic [VW-1:0] prop_val,
    input  logic [TW-1:0] prop_time,
    input  logic [TW-1:0] inertial_dly,
    input  logic          retire,
    input  logic [TW-1:0] cur_time,
    output logic [VW-1:0] out_val,
    output logic [1:0]    pend_cnt,
    output logic [TW-1:0] head_time,
    output logic [VW-1:0] head_val,
    output logic [TW-1:0] tail_time,
    output logic [VW-1:0] tail_val,
    output logic          overflow
);
    typedef struct packed {
        logic [VW-1:0] commit;
        logic [1:0]    cnt;
        logic [TW-1:0] t0;
        logic [VW-1:0] v0;
        logic [TW-1:0] t1;
        logic [VW-1:0] v1;
        logic          ovf;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]    r_cnt;
    logic [VW-1:0] r_commit;
    logic [TW-1:0] r_t0, r_t1;
    logic [VW-1:0] r_v0, r_v1;
    place_e        place;
    logic [1:0]    m_cnt;
    logic [TW-1:0] m_t0, m_t1;
    logic [VW-1:0] m_v0, m_v1;
    logic          m_ovf;

    pef_retire #(.TW(TW)) u_retire (
        .retire   (retire),
        .cur_time (cur_time),
        .cnt_i    (st_q.cnt),
        .commit_i (st_q.commit),
        .t0_i     (st_q.t0),
        .v0_i     (st_q.v0),
        .t1_i     (st_q.t1),
        .v1_i     (st_q.v1),
        .cnt_o    (r_cnt),
        .commit_o (r_commit),
        .t0_o     (r_t0),
        .v0_o     (r_v0),
        .t1_o     (r_t1),
        .v1_o     (r_v1)
    );

    pef_classify #(.TW(TW)) u_classify (
        .cnt_i    (r_cnt),
        .t0_i     (r_t0),
        .t1_i     (r_t1),
        .new_time (prop_time),
        .place    (place)
    );

    pef_merge #(.TW(TW)) u_merge (
        .valid    (prop_valid),
        .place    (place),
        .new_val  (prop_val),
        .new_time (prop_time),
        .inertial (inertial_dly),
        .cnt_i    (r_cnt),
        .commit_i (r_commit),
        .t0_i     (r_t0),
        .v0_i     (r_v0),
        .t1_i     (r_t1),
        .v1_i     (r_v1),
        .cnt_o    (m_cnt),
        .t0_o     (m_t0),
        .v0_o     (m_v0),
        .t1_o     (m_t1),
        .v1_o     (m_v1),
        .ovf_o    (m_ovf)
    );

    always_comb begin
        st_d        = st_q;
        st_d.commit = r_commit;
        st_d.cnt    = m_cnt;
        st_d.t0     = m_t0;
        st_d.v0     = m_v0;
        st_d.t1     = m_t1;
        st_d.v1     = m_v1;
        st_d.ovf    = m_ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{commit: V_UNK, cnt: 2'd0, t0: '0, v0: V_UNK,
                      t1: '0, v1: V_UNK, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_val   = st_q.commit;
    assign pend_cnt  = st_q.cnt;
    assign head_time = st_q.t0;
    assign head_val  = st_q.v0;
    assign tail_time = st_q.t1;
    assign tail_val  = st_q.v1;
    assign overflow  = st_q.ovf;

    // R10: list bound, time order and distinct neighbours
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt != 2'd3);
    a_r10_time_order: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == 2'd2) |-> (head_time <= tail_time));
    a_r10_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == 2'd2) |-> (head_val != tail_val));

    // R8: a matching retire commits the head value
    a_r8_retire_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && pend_cnt != 2'd0 && cur_time == head_time)
        |=> (out_val == $past(head_val)));
    // R8: the committed output moves only on a matching retire
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire && pend_cnt != 2'd0 && cur_time == head_time)
        |=> $stable(out_val));

    // R7: an overflow always leaves the list full
    a_r7_full_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (pend_cnt == 2'd2));

    // R2: a proposal equal to the committed value is dropped on an empty list
    a_r2_drop_same: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !retire && pend_cnt == 2'd0 && prop_val == out_val)
        |=> (pend_cnt == 2'd0));

    // R3: an append equal to the last value is dropped
    a_r3_drop_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_valid && !retire && pend_cnt == 2'd1 && prop_time > head_time
         && prop_val == head_val)
        |=> (pend_cnt == 2'd1 && $stable(head_time) && $stable(head_val)));
endmodule

// File: tb/pending_event_filter_bench.sv
module pending_event_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] L0 = 2'b00;
    localparam logic [1:0] L1 = 2'b11;
    localparam logic [1:0] LX = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prop_valid;
    logic [1:0]  prop_val;
    logic [15:0] prop_time;
    logic [15:0] inertial_dly;
    logic        retire;
    logic [15:0] cur_time;
    logic [1:0]  out_val;
    logic [1:0]  pend_cnt;
    logic [15:0] head_time;
    logic [1:0]  head_val;
    logic [15:0] tail_time;
    logic [1:0]  tail_val;
    logic        overflow;

    int unsigned checks = 0;
    int unsigned errors = 0;

    // reference model state
    int unsigned mc;
    logic [1:0]  mcommit;
    logic [15:0] mt [2];
    logic [1:0]  mv [2];
    logic        movf;

    always #(CLK_PERIOD/2) clk = ~clk;

    pending_event_filter #(.TW(16)) u_pending_event_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .prop_valid   (prop_valid),
        .prop_val     (prop_val),
        .prop_time    (prop_time),
        .inertial_dly (inertial_dly),
        .retire       (retire),
        .cur_time     (cur_time),
        .out_val      (out_val),
        .pend_cnt     (pend_cnt),
        .head_time    (head_time),
        .head_val     (head_val),
        .tail_time    (tail_time),
        .tail_val     (tail_val),
        .overflow     (overflow)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_update(input logic pv, input logic [1:0] v, input logic [15:0] t,
                                input logic rt, input logic [15:0] ct, input logic [15:0] idl);
        logic [1:0]  lastv;
        logic [1:0]  origv;
        logic [15:0] d;
        movf = 1'b0;
        if (rt && mc > 0 && mt[0] == ct) begin
            mcommit = mv[0];
            mt[0] = mt[1];
            mv[0] = mv[1];
            mc = mc - 1;
        end
        if (pv) begin
            if (mc == 0) begin
                if (v != mcommit) begin
                    mt[0] = t; mv[0] = v; mc = 1;
                end
            end else if (t > mt[mc-1]) begin
                lastv = mv[mc-1];
                origv = (mc == 2) ? mv[0] : mcommit;
                d = t - mt[mc-1];
                if (v != lastv) begin
                    if (v == origv && d < idl) mc = mc - 1;
                    else if (mc == 1) begin mt[1] = t; mv[1] = v; mc = 2; end
                    else movf = 1'b1;
                end
            end else if (t <= mt[0]) begin
                if (mv[0] == v) begin
                    mt[0] = t;
                end else begin
                    if (mc == 2) movf = 1'b1;
                    mt[1] = mt[0]; mv[1] = mv[0];
                    mt[0] = t; mv[0] = v; mc = 2;
                end
            end else begin
                if (v != mv[0]) begin
                    if (v != mv[1]) movf = 1'b1;
                    mt[1] = t; mv[1] = v;
                end
            end
        end
    endtask

    task automatic compare_model(input string tag);
        chk({tag, " count"}, 32'(pend_cnt), 32'(mc));
        chk({tag, " commit"}, 32'(out_val), 32'(mcommit));
        chk({tag, " overflow"}, 32'(overflow), 32'(movf));
        if (mc >= 1) begin
            chk({tag, " head_time"}, 32'(head_time), 32'(mt[0]));
            chk({tag, " head_val"}, 32'(head_val), 32'(mv[0]));
        end
        if (mc == 2) begin
            chk({tag, " tail_time"}, 32'(tail_time), 32'(mt[1]));
            chk({tag, " tail_val"}, 32'(tail_val), 32'(mv[1]));
        end
    endtask

    task automatic step(input string tag, input logic pv, input logic [1:0] v, input logic [15:0] t,
                        input logic rt, input logic [15:0] ct, input logic [15:0] idl);
        @(negedge clk);
        prop_valid = pv; prop_val = v; prop_time = t;
        retire = rt; cur_time = ct; inertial_dly = idl;
        model_update(pv, v, t, rt, ct, idl);
        @(posedge clk);
        #1;
        compare_model(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired got=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] vals [3];
        int unsigned now;
        logic [15:0] idl;
        vals[0] = L0; vals[1] = L1; vals[2] = LX;
        void'($urandom(32'd20151220));
        rst_n = 1'b0; prop_valid = 1'b0; prop_val = L0; prop_time = '0;
        retire = 1'b0; cur_time = '0; inertial_dly = '0;
        mc = 0; mcommit = LX; mt[0] = '0; mt[1] = '0; mv[0] = LX; mv[1] = LX; movf = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 commit after reset", 32'(out_val), 32'(LX));
        chk("R1 count after reset", 32'(pend_cnt), 32'd0);
        chk("R1 overflow after reset", 32'(overflow), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: empty list
        step("R2", 1, LX, 16'd5, 0, 16'd0, 16'd0);
        chk("R2 same as committed dropped", 32'(pend_cnt), 32'd0);
        step("R2", 1, L0, 16'd5, 0, 16'd0, 16'd0);
        chk("R2 different accepted", 32'(pend_cnt), 32'd1);
        // R8: matching retire
        step("R8", 0, L0, 16'd0, 1, 16'd5, 16'd0);
        chk("R8 popped value committed", 32'(out_val), 32'(L0));
        chk("R8 list empty after pop", 32'(pend_cnt), 32'd0);
        step("R8", 0, L0, 16'd0, 1, 16'd5, 16'd0);
        chk("R8 retire on empty list keeps commit", 32'(out_val), 32'(L0));

        // R3: append
        step("R3", 1, L1, 16'd10, 0, 16'd0, 16'd0);
        step("R3", 1, L1, 16'd20, 0, 16'd0, 16'd0);
        chk("R3 duplicate append dropped", 32'(pend_cnt), 32'd1);
        step("R3", 1, L0, 16'd30, 0, 16'd0, 16'd0);
        chk("R3 distinct append stored", 32'(tail_time), 32'd30);

        // R7: third distinct event
        step("R7", 1, L1, 16'd40, 0, 16'd0, 16'd0);
        chk("R7 overflow flag", 32'(overflow), 32'd1);
        chk("R7 earliest two kept", 32'(tail_time), 32'd30);
        step("R7", 0, L0, 16'd0, 0, 16'd0, 16'd0);
        chk("R7 overflow one cycle only", 32'(overflow), 32'd0);

        // R4: before head with same value as head
        step("R4", 1, L1, 16'd5, 0, 16'd0, 16'd0);
        chk("R4 new head time", 32'(head_time), 32'd5);
        chk("R4 obsolete head removed, second kept", 32'(tail_time), 32'd30);

        // R5: between two entries
        step("R5", 1, L1, 16'd20, 0, 16'd0, 16'd0);
        chk("R5 same as head dropped", 32'(tail_time), 32'd30);
        step("R5", 1, L0, 16'd20, 0, 16'd0, 16'd0);
        chk("R5 later same-value entry replaced", 32'(tail_time), 32'd20);

        // R8: mismatched retire, then match
        step("R8", 0, L0, 16'd0, 1, 16'd6, 16'd0);
        chk("R8 mismatched time no pop", 32'(pend_cnt), 32'd2);
        step("R8", 0, L0, 16'd0, 1, 16'd5, 16'd0);
        chk("R8 pop commits head", 32'(out_val), 32'(L1));

        // R6: inertial cancel against committed value
        step("R6", 1, L1, 16'd25, 0, 16'd0, 16'd8);
        chk("R6 narrow pulse against commit cancelled", 32'(pend_cnt), 32'd0);
        step("R6", 1, L0, 16'd40, 0, 16'd0, 16'd8);
        step("R6", 1, L1, 16'd50, 0, 16'd0, 16'd8);
        chk("R6 wide pulse kept", 32'(pend_cnt), 32'd2);

        // R9: retire then proposal in one cycle
        step("R9", 1, L0, 16'd45, 1, 16'd40, 16'd8);
        chk("R9 commit from pop", 32'(out_val), 32'(L0));
        chk("R9 proposal filtered after pop", 32'(head_time), 32'd45);

        // R6: inertial cancel against head value
        step("R6", 1, L0, 16'd53, 0, 16'd0, 16'd8);
        chk("R6 narrow pulse against head cancelled", 32'(pend_cnt), 32'd1);

        // random phase against the model
        now = 100;
        idl = 16'd4;
        for (int i = 0; i < 4000; i++) begin
            logic        pv;
            logic        rt;
            logic [15:0] ct;
            now = now + ($urandom % 3);
            if ((i % 64) == 0) idl = 16'($urandom % 12);
            pv = ($urandom % 3) != 0;
            rt = ($urandom % 3) == 0;
            ct = (mc > 0 && ($urandom % 2) == 1) ? mt[0] : 16'(now);
            step("RND", pv, vals[$urandom % 3], 16'(now + ($urandom % 24)), rt, ct, idl);
        end

        @(negedge clk);
        prop_valid = 1'b0; retire = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule